// File: doc/BRIEF.md
# Redundant Purse Value Engine

This block carries out the arithmetic of an electronic purse on 16-byte value blocks. A value block keeps one signed 32-bit amount three times (plain, inverted, plain) and a one-byte address tag four times (plain and inverted, alternating). When a restore, increment or decrement command arrives, the engine reads the presented source image and checks every redundant copy against its partner. If all copies agree, it restores, adds or subtracts into a volatile holding register. If any copy disagrees, it reports a format error and computes nothing.

Nothing reaches storage until a transfer command commits the held amount. On a transfer the engine builds a complete, well-formed block for the destination. The three amount copies come from the holding register. The four address bytes are taken unchanged from the destination image presented with the command, so value commands never alter an address tag. A transfer while no result is held is refused. The block does not check permissions and does not hold storage. The caller supplies block images and writes the result back.

Top module: `value_purse_engine`

## Requirements
- R1: While reset is held and after its release, `done`, `fmt_err`, `xfer_rej`, `wb_valid` and `hold_valid` are 0, and `hold_value` and `wb_block` are all zeros.
- R2: Block layout, where byte k is `src_block[8k+7:8k]` and the amount is stored least significant byte first. Bytes 0-3 hold the amount, bytes 4-7 hold its bitwise inverse, bytes 8-11 hold the amount again. Byte 12 is the address, byte 13 its inverse, byte 14 the address and byte 15 its inverse. For opcodes 0-2, any mismatch among these copies gives `fmt_err`=1 together with `done`.
- R3: Opcode 0 (restore) on a well-formed source sets `hold_value` to the source amount and sets `hold_valid` to 1.
- R4: Opcode 1 (increment) sets `hold_value` to the source amount plus `operand`, modulo 2^32, and sets `hold_valid` to 1.
- R5: Opcode 2 (decrement) sets `hold_value` to the source amount minus `operand`, modulo 2^32, and sets `hold_valid` to 1.
- R6: A command that reports `fmt_err` leaves `hold_value` and `hold_valid` unchanged.
- R7: Opcode 3 (transfer) with `hold_valid`=1 pulses `wb_valid`. It drives `wb_block` with the held amount in the R2 layout, and copies bytes 12-15 unchanged from `src_block`.
- R8: Opcode 3 with `hold_valid`=0 pulses `xfer_rej`, keeps `wb_valid` at 0 and leaves `wb_block` unchanged.
- R9: A transfer leaves `hold_valid` and `hold_value` unchanged, so the held result can be committed again.
- R10: A command sampled on one rising edge pulses `done` for exactly one cycle after that edge. `fmt_err`, `xfer_rej` and `wb_valid` are high only in that same cycle, and at most one of them is high.
- R11: While `cmd_valid` is 0, `done` stays 0 and the holding register does not change, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 restore, 1 increment, 2 decrement, 3 transfer |
| operand | input | 32 | Amount added or subtracted |
| src_block | input | 128 | Source image (ops 0-2) or destination image (op 3) |
| wb_block | output | 128 | Formatted block to write back |
| wb_valid | output | 1 | Write-back pulse |
| done | output | 1 | Command completion pulse |
| fmt_err | output | 1 | Redundancy check failed |
| xfer_rej | output | 1 | Transfer refused, nothing held |
| hold_valid | output | 1 | Holding register has a result |
| hold_value | output | 32 | Holding register amount |

## Verification
Every result comes from a single register stage. The outputs for a command sampled on a rising edge are due on the very next edge. The driver applies each command at a falling edge and pushes the expected outcome into a queue. The monitor pops that outcome and compares it when it sees `done` at the following falling edge, half a period after the results settle. An unexpected `done`, or a queue that never drains, counts as a failure. The idle check holds `cmd_valid` low for several cycles and confirms that no completion appears and that the held result stays the same.

// File: rtl/value_purse_engine.sv
module value_purse_engine #(
  parameter int VW = 32,
  parameter int AW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [VW-1:0]            operand,
  input  logic [3*VW+4*AW-1:0]     src_block,
  output logic [3*VW+4*AW-1:0]     wb_block,
  output logic                     wb_valid,
  output logic                     done,
  output logic                     fmt_err,
  output logic                     xfer_rej,
  output logic                     hold_valid,
  output logic [VW-1:0]            hold_value
);
  localparam int BW    = 3*VW + 4*AW;
  localparam int ABASE = 3*VW;

  localparam logic [1:0] OP_RESTORE  = 2'd0;
  localparam logic [1:0] OP_INCR     = 2'd1;
  localparam logic [1:0] OP_DECR     = 2'd2;
  localparam logic [1:0] OP_TRANSFER = 2'd3;

  logic [VW-1:0] amt_a, amt_n, amt_b;
  logic [AW-1:0] tag [4];
  logic          amt_ok, tag_ok, src_ok;
  logic [VW-1:0] calc;
  logic          is_xfer;

  assign amt_a = src_block[VW-1:0];
  assign amt_n = src_block[2*VW-1:VW];
  assign amt_b = src_block[3*VW-1:2*VW];

  for (genvar k = 0; k < 4; k++) begin : g_tag
    assign tag[k] = src_block[ABASE+k*AW +: AW];
  end

  assign amt_ok  = (amt_a == amt_b) && (amt_n == ~amt_a);
  assign tag_ok  = (tag[2] == tag[0]) && (tag[1] == ~tag[0]) && (tag[3] == ~tag[0]);
  assign src_ok  = amt_ok && tag_ok;
  assign is_xfer = (cmd_op == OP_TRANSFER);

  always_comb begin
    case (cmd_op)
      OP_INCR: calc = amt_a + operand;
      OP_DECR: calc = amt_a - operand;
      default: calc = amt_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_block   <= '0;
      wb_valid   <= 1'b0;
      done       <= 1'b0;
      fmt_err    <= 1'b0;
      xfer_rej   <= 1'b0;
      hold_valid <= 1'b0;
      hold_value <= '0;
    end else begin
      done     <= cmd_valid;
      wb_valid <= 1'b0;
      fmt_err  <= 1'b0;
      xfer_rej <= 1'b0;
      if (cmd_valid) begin
        if (is_xfer) begin
          if (hold_valid) begin
            wb_valid <= 1'b1;
            wb_block <= {src_block[BW-1:ABASE], hold_value, ~hold_value, hold_value};
          end else begin
            xfer_rej <= 1'b1;
          end
        end else if (!src_ok) begin
          fmt_err <= 1'b1;
        end else begin
          hold_value <= calc;
          hold_valid <= 1'b1;
        end
      end
    end
  end

  // R6
  hold_kept_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fmt_err) |-> (hold_value == $past(hold_value) && hold_valid == $past(hold_valid)));

  // R8
  xfer_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(hold_valid));

  // R9
  hold_kept_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || xfer_rej) |-> (hold_value == $past(hold_value) && hold_valid == $past(hold_valid)));

  // R10
  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fmt_err, xfer_rej, wb_valid}) && ((fmt_err || xfer_rej || wb_valid) -> done));

  // R10
  done_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_valid));

  // R11
  idle_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cmd_valid) && $past(rst_n)) |-> ($stable(hold_value) && $stable(hold_valid)));

  // R7
  wb_matches_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_block[VW-1:0] == hold_value));
endmodule

// File: tb/value_purse_engine_bench.sv
module value_purse_engine_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic         fe;
    logic         rj;
    logic         wv;
    logic         hv;
    logic [31:0]  hval;
    logic [127:0] wb;
    string        tag;
  } exp_t;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         cmd_valid = 0;
  logic [1:0]   cmd_op = 0;
  logic [31:0]  operand = 0;
  logic [127:0] src_block = 0;
  logic [127:0] wb_block;
  logic         wb_valid, done, fmt_err, xfer_rej, hold_valid;
  logic [31:0]  hold_value;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  exp_t q[$];

  logic         m_hv = 0;
  logic [31:0]  m_val = 0;
  logic [127:0] m_wb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  value_purse_engine u_value_purse_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .operand(operand), .src_block(src_block), .wb_block(wb_block),
    .wb_valid(wb_valid), .done(done), .fmt_err(fmt_err), .xfer_rej(xfer_rej),
    .hold_valid(hold_valid), .hold_value(hold_value));

  function automatic logic [127:0] mk_block(input logic [31:0] v, input logic [7:0] a);
    return {~a, a, ~a, a, v, ~v, v};
  endfunction

  function automatic logic well_formed(input logic [127:0] b);
    logic ok = 1'b1;
    if (b[95:64] != b[31:0]) ok = 1'b0;
    if (b[63:32] != ~b[31:0]) ok = 1'b0;
    if (b[119:112] != b[103:96]) ok = 1'b0;
    if (b[111:104] != ~b[103:96]) ok = 1'b0;
    if (b[127:120] != ~b[103:96]) ok = 1'b0;
    return ok;
  endfunction

  task automatic fail_line(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] opd, input logic [127:0] blk, input string tag);
    exp_t e;
    e.fe = 0; e.rj = 0; e.wv = 0; e.tag = tag;
    if (op == 2'd3) begin
      if (m_hv) begin
        e.wv = 1;
        m_wb = {blk[127:96], m_val, ~m_val, m_val};
      end else e.rj = 1;
    end else if (!well_formed(blk)) begin
      e.fe = 1;
    end else begin
      case (op)
        2'd1: m_val = blk[31:0] + opd;
        2'd2: m_val = blk[31:0] - opd;
        default: m_val = blk[31:0];
      endcase
      m_hv = 1;
    end
    e.hv = m_hv; e.hval = m_val; e.wb = m_wb;
    q.push_back(e);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; operand = opd; src_block = blk;
    @(negedge clk);
    cmd_valid = 0; operand = 32'hDEAD_BEEF; src_block = ~blk;
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      checks++;
      if (q.size() == 0) begin
        fail_line("R10", "unexpected done", 128'(done), 128'(0));
      end else begin
        exp_t e;
        e = q.pop_front();
        if (fmt_err !== e.fe)        fail_line(e.tag, "fmt_err", 128'(fmt_err), 128'(e.fe));
        else if (xfer_rej !== e.rj)  fail_line(e.tag, "xfer_rej", 128'(xfer_rej), 128'(e.rj));
        else if (wb_valid !== e.wv)  fail_line(e.tag, "wb_valid", 128'(wb_valid), 128'(e.wv));
        else if (hold_valid !== e.hv) fail_line(e.tag, "hold_valid", 128'(hold_valid), 128'(e.hv));
        else if (hold_value !== e.hval) fail_line(e.tag, "hold_value", 128'(hold_value), 128'(e.hval));
        else if (wb_block !== e.wb)  fail_line(e.tag, "wb_block", wb_block, e.wb);
      end
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fail_line("WDOG", "watchdog expired", 128'(q.size()), 128'(0));
    summary();
  end

  initial begin
    logic [127:0] b;
    int d0;
    repeat (3) @(negedge clk);
    checks++;
    if ({done, fmt_err, xfer_rej, wb_valid, hold_valid} !== 5'b0 || hold_value !== 0 || wb_block !== 0)
      fail_line("R1", "reset outputs", {wb_block[63:0], hold_value, 27'b0, done, fmt_err, xfer_rej, wb_valid, hold_valid}, 128'(0));
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (hold_valid !== 0 || done !== 0) fail_line("R1", "after release", 128'({done, hold_valid}), 128'(0));

    issue(2'd3, 0, mk_block(32'd5, 8'h10), "R8");
    issue(2'd0, 0, mk_block(32'h1234_5678, 8'h21), "R3");
    issue(2'd1, 32'd100, mk_block(32'd1000, 8'h21), "R4");
    issue(2'd1, 32'd1, mk_block(32'h7FFF_FFFF, 8'h05), "R4");
    issue(2'd1, 32'd1, mk_block(32'hFFFF_FFFF, 8'h05), "R4");
    issue(2'd2, 32'd250, mk_block(32'd1000, 8'h3C), "R5");
    issue(2'd2, 32'd1, mk_block(32'd0, 8'h3C), "R5");
    issue(2'd3, 0, mk_block(32'd77, 8'h2A), "R7");
    issue(2'd3, 0, {8'h0F, 8'h33, 8'hAA, 8'h55, 96'h0}, "R9");

    b = mk_block(32'd42, 8'h11); b[70] = ~b[70];
    issue(2'd0, 0, b, "R2");
    b = mk_block(32'd42, 8'h11); b[40] = ~b[40];
    issue(2'd1, 1, b, "R2");
    b = mk_block(32'd42, 8'h11); b[3] = ~b[3];
    issue(2'd2, 1, b, "R6");
    b = mk_block(32'd42, 8'h11); b[108] = ~b[108];
    issue(2'd0, 0, b, "R2");
    b = mk_block(32'd42, 8'h11); b[115] = ~b[115];
    issue(2'd0, 0, b, "R2");
    b = mk_block(32'd42, 8'h11); b[127] = ~b[127];
    issue(2'd1, 7, b, "R6");
    issue(2'd3, 0, mk_block(32'd0, 8'h3F), "R9");

    repeat (2) @(negedge clk);
    d0 = done_cnt;
    cmd_op = 2'd1; operand = 32'h1111_1111; src_block = mk_block(32'd9, 8'h01);
    repeat (6) @(negedge clk);
    checks++;
    if (done_cnt != d0 || hold_value !== m_val || hold_valid !== m_hv)
      fail_line("R11", "idle changed state", 128'(hold_value), 128'(m_val));

    issue(2'd0, 0, mk_block(32'h8000_0000, 8'h00), "R3");
    issue(2'd3, 0, mk_block(32'd1, 8'hFF), "R7");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) fail_line("R10", "results missing", 128'(q.size()), 128'(0));
    summary();
  end
endmodule